// File: doc/BRIEF.md
# Byte Serializer with Word Frame Clock

The block converts a parallel word into a serial bit stream. It sends one bit per rising clock edge, least significant bit first. It also drives a frame clock that is high for the first half of each word and low for the second half. Downstream logic uses the rising edge of the frame clock to find word boundaries. An upstream source can use the falling edge as its cue to present the next parallel word. Words follow one another with no idle bit between them. The next word is captured on the same cycle in which the last bit of the current word is replaced.

A hold input freezes the whole block without glitches. The hold input is registered on the falling clock edge. All rising-edge logic is qualified by that registered value. A freeze or a restart therefore always begins on a whole bit boundary. While frozen, the serial output, the frame clock and the bit position keep their values. When the hold is released, the stream continues exactly where it stopped.

Top module: `ser_framer`

## Requirements
- R1: While `rst_ni` is low, `ser_o` and `frm_o` are 0, whatever the clock does.
- R2: Bit 0 of each captured word appears on `ser_o` first. Bits 1 through 7 follow, one per enabled rising edge, in ascending order.
- R3: `frm_o` is 1 while bits 0–3 of a word are on `ser_o` and 0 while bits 4–7 are on it. It therefore rises together with bit 0.
- R4: Bit 0 of the next word directly follows bit 7 of the current word. There is no idle cycle between them.
- R5: `par_i` is sampled only on the enabled edge that starts a word. Changes on `par_i` at any other time do not affect `ser_o`.
- R6: A high `hold_i` is sampled on a falling clock edge. The rising edges that follow then change neither `ser_o`, nor `frm_o`, nor the bit position.
- R7: A low `hold_i` is sampled on a falling clock edge. The next rising edge then resumes the stream at the bit after the one held, so no bit is lost or repeated.
- R8: After reset is released, no word is captured until the first enabled edge. Outputs stay 0 while `hold_i` is high. The first enabled edge captures `par_i` and shows its bit 0.
- R9: A hold that covers the edge on which a new word would start delays the capture. The capture happens on the resuming edge, and `par_i` values seen during the hold are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock; the datapath uses rising edges and the hold register uses falling edges |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hold_i | input | 1 | Freeze request: 1 suspends the block and 0 runs it, sampled on the falling edge |
| par_i | input | 8 | Parallel word; bit 0 is sent first |
| ser_o | output | 1 | Serial data |
| frm_o | output | 1 | Word frame clock, high for the first half of each word |

## Verification
The hardest case to reach from the ports is a hold that lands exactly on the word-boundary edge. There, freezing must also delay the capture of `par_i`. The stimulus raises `hold_i` right after bit 7 appears, changes `par_i` to a decoy word during the freeze, and restores the intended word just before releasing the hold. The stimulus also freezes the block in the middle of a word, at the first bit and at a frame-clock transition. In each case it checks every held cycle and every remaining bit against the word that was sent.

// File: rtl/ser_pkg.sv
package ser_pkg;
  localparam int unsigned SER_W_DEF = 8;

  typedef enum logic [0:0] {
    HALF_LO = 1'b0,
    HALF_HI = 1'b1
  } frm_half_e;
endpackage

// File: rtl/ser_run_gate.sv
module ser_run_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_i,
  output logic run_o
);
  logic run_q;

  // falling-edge capture so rising-edge logic sees a settled enable
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else         run_q <= ~hold_i;
  end

  assign run_o = run_q;
endmodule

// File: rtl/ser_bit_counter.sv
module ser_bit_counter #(
  parameter int unsigned W  = ser_pkg::SER_W_DEF,
  localparam int unsigned CW = $clog2(W)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  output logic          load_o,
  output logic          primed_o,
  output logic [CW-1:0] cnt_o
);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [CW-1:0] cnt_q;
  logic          primed_q;
  logic          wrap;

  assign wrap   = (cnt_q == LAST);
  assign load_o = run_i & (~primed_q | wrap);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      primed_q <= 1'b0;
    end else if (run_i) begin
      if (load_o) begin
        cnt_q    <= '0;
        primed_q <= 1'b1;
      end else begin
        cnt_q    <= cnt_q + 1'b1;
      end
    end
  end

  assign primed_o = primed_q;
  assign cnt_o    = cnt_q;
endmodule

// File: rtl/ser_shifter.sv
module ser_shifter #(
  parameter int unsigned W = ser_pkg::SER_W_DEF
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         load_i,
  input  logic [W-1:0] par_i,
  output logic         ser_o
);
  logic [W-2:0] rem_q;
  logic [W-2:0] rem_d;
  logic         ser_q;
  logic         ser_d;

  genvar gi;
  generate
    for (gi = 0; gi < W - 1; gi++) begin : g_stage
      if (gi == W - 2) begin : g_top
        assign rem_d[gi] = load_i ? par_i[gi+1] : 1'b0;
      end else begin : g_mid
        assign rem_d[gi] = load_i ? par_i[gi+1] : rem_q[gi+1];
      end
    end
  endgenerate

  assign ser_d = load_i ? par_i[0] : rem_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= '0;
      ser_q <= 1'b0;
    end else if (run_i) begin
      rem_q <= rem_d;
      ser_q <= ser_d;
    end
  end

  assign ser_o = ser_q;
endmodule

// File: rtl/ser_frame_gen.sv
module ser_frame_gen #(
  parameter int unsigned W  = ser_pkg::SER_W_DEF,
  localparam int unsigned CW = $clog2(W)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          load_i,
  input  logic [CW-1:0] cnt_i,
  output logic          frm_o
);
  import ser_pkg::*;

  localparam logic [CW:0] HALF = (CW+1)'(W / 2);

  logic [CW:0] cnt_nxt;
  frm_half_e   frm_q;
  frm_half_e   frm_d;

  assign cnt_nxt = {1'b0, cnt_i} + 1'b1;

  always_comb begin
    if (load_i)             frm_d = HALF_HI;
    else if (cnt_nxt < HALF) frm_d = HALF_HI;
    else                    frm_d = HALF_LO;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    frm_q <= HALF_LO;
    else if (run_i) frm_q <= frm_d;
  end

  assign frm_o = (frm_q == HALF_HI);
endmodule

// File: rtl/ser_framer.sv
module ser_framer #(
  parameter int unsigned W = ser_pkg::SER_W_DEF
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         hold_i,
  input  logic [W-1:0] par_i,
  output logic         ser_o,
  output logic         frm_o
);
  localparam int unsigned CW = $clog2(W);

  logic          run_q;
  logic          load;
  logic          primed_q;
  logic [CW-1:0] cnt_q;

  ser_run_gate u_gate (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hold_i (hold_i),
    .run_o  (run_q)
  );

  ser_bit_counter #(.W(W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run_q),
    .load_o   (load),
    .primed_o (primed_q),
    .cnt_o    (cnt_q)
  );

  ser_shifter #(.W(W)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run_q),
    .load_i (load),
    .par_i  (par_i),
    .ser_o  (ser_o)
  );

  ser_frame_gen #(.W(W)) u_frm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run_q),
    .load_i (load),
    .cnt_i  (cnt_q),
    .frm_o  (frm_o)
  );
endmodule

// File: rtl/ser_framer_chk.sv
module ser_framer_chk #(
  parameter int unsigned W  = ser_pkg::SER_W_DEF,
  localparam int unsigned CW = $clog2(W)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          run_i,
  input logic          primed_i,
  input logic [CW-1:0] cnt_i,
  input logic          par0_i,
  input logic          ser_i,
  input logic          frm_i
);
  localparam logic [CW-1:0] LAST = CW'(W - 1);
  localparam logic [CW-1:0] HALF = CW'(W / 2);

  AST_RESET_QUIET: assert property (@(posedge clk_i) !rst_ni |-> !ser_i && !frm_i); // R1

  AST_FIRST_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && (!primed_i || cnt_i == LAST) |=> ser_i == $past(par0_i)); // R2

  AST_FRAME_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed_i |-> frm_i == (cnt_i < HALF)); // R3

  AST_FRAME_RISE_AT_BIT0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(frm_i) |-> cnt_i == '0); // R3

  AST_WRAP_NO_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && primed_i && cnt_i == LAST |=> cnt_i == '0 && frm_i); // R4

  AST_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> $stable(ser_i) && $stable(frm_i) && $stable(cnt_i)); // R6

  AST_STEP_ON_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && primed_i && cnt_i != LAST |=> cnt_i == $past(cnt_i) + 1'b1); // R7

  AST_IDLE_UNTIL_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !primed_i |-> !ser_i && !frm_i); // R8
endmodule

bind ser_framer ser_framer_chk #(.W(W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .run_i    (run_q),
  .primed_i (primed_q),
  .cnt_i    (cnt_q),
  .par0_i   (par_i[0]),
  .ser_i    (ser_o),
  .frm_i    (frm_o)
);

// File: tb/ser_framer_test.sv
`timescale 1ns/1ps
module ser_framer_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       hold_i = 1'b1;
  logic [7:0] par_i = 8'h00;
  logic       ser_o;
  logic       frm_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk_i = ~clk_i;

  ser_framer #(.W(8)) uut (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hold_i (hold_i),
    .par_i  (par_i),
    .ser_o  (ser_o),
    .frm_o  (frm_o)
  );

  task automatic report();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  task automatic chk(input logic act, input logic exp, input string req, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  // sends one word; optional freeze after bit pk for plen cycles
  task automatic play(input logic [7:0] w, input logic [7:0] nxt, input int pk,
                      input int plen, input string tag0);
    for (int k = 0; k < 8; k++) begin
      tick();
      chk(ser_o, w[k], (k == 0) ? tag0 : "R2", $sformatf("bit %0d of %02h", k, w));
      chk(frm_o, (k < 4), "R3", $sformatf("frame at bit %0d", k));
      if (k == 0) par_i = ~nxt ^ 8'h5a;  // decoy, must be ignored (R5)
      if (k == 4) par_i = nxt;
      if (k == pk) begin
        hold_i = 1'b1;
        par_i  = ~nxt;                   // decoy during freeze (R9)
        for (int j = 0; j < plen; j++) begin
          tick();
          chk(ser_o, w[k], "R6", $sformatf("held bit %0d", k));
          chk(frm_o, (k < 4), "R6", "held frame");
        end
        par_i  = (k >= 4) ? nxt : par_i;
        hold_i = 1'b0;
        if (k < 4) par_i = ~nxt ^ 8'h5a;
      end
    end
  endtask

  task automatic t_reset_state();
    repeat (3) tick();
    chk(ser_o, 1'b0, "R1", "ser in reset");
    chk(frm_o, 1'b0, "R1", "frm in reset");
  endtask

  task automatic t_idle_after_reset();
    rst_ni = 1'b1;
    par_i  = 8'hff;
    repeat (4) begin
      tick();
      chk(ser_o, 1'b0, "R8", "ser before first enable");
      chk(frm_o, 1'b0, "R8", "frm before first enable");
    end
  endtask

  task automatic t_stream();
    par_i  = 8'ha5;
    hold_i = 1'b0;
    play(8'ha5, 8'h3c, -1, 0, "R8");
    play(8'h3c, 8'h01, -1, 0, "R4");
    play(8'h01, 8'h80, -1, 0, "R4");
  endtask

  task automatic t_freeze_mid();
    play(8'h80, 8'hd2, 3, 4, "R4");  // freeze across frame fall
    play(8'hd2, 8'h6b, 0, 2, "R7");  // freeze right on bit 0
    play(8'h6b, 8'hc4, 5, 3, "R7");
  endtask

  task automatic t_freeze_boundary();
    play(8'hc4, 8'h39, 7, 3, "R7");  // freeze covers word-start edge
    play(8'h39, 8'hf0, -1, 0, "R9"); // must be the restored word
    play(8'hf0, 8'h0f, 7, 1, "R4");
    play(8'h0f, 8'h00, -1, 0, "R9");
  endtask

  task automatic t_reset_mid();
    tick();
    tick();
    #0.5;
    rst_ni = 1'b0;
    #0.5;
    chk(ser_o, 1'b0, "R1", "ser after async reset");
    chk(frm_o, 1'b0, "R1", "frm after async reset");
    tick();
    rst_ni = 1'b1;
    par_i  = 8'h96;
    play(8'h96, 8'h55, -1, 0, "R8");
  endtask

  initial begin
    t_reset_state();
    t_idle_after_reset();
    t_stream();
    t_freeze_mid();
    t_freeze_boundary();
    t_reset_mid();
    report();
  end

  initial begin
    #(200000 * 5);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end
endmodule